// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer for a processor subsystem. Software sets it up through a small register bus and must then keep it alive. The block has a register for enable and response mode, a register that holds two period codes, and a restart register. When software turns the watchdog on, a down-counter starts. That counter reaches zero unless software writes one fixed key value to the restart register in time. Writes of any other value to the restart register do nothing.

Each 4-bit period code n selects a period of 2^(BASE_LOG2+n) clock cycles, and BASE_LOG2 is 16 by default. The upper code gives the first period after enabling. The lower code gives every period after a reload. In the direct mode, the first expiry raises a system-reset pulse of fixed length. In the two-stage mode, the first expiry raises an interrupt and starts another period, and a second expiry with no restart in between raises the reset pulse. Once the watchdog is on, software cannot turn it off. Only a reset of the block clears it.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, enable, mode, both period codes, `irq` and `sys_rst` are all 0, and reads of control (0x0) and range (0x4) return 0.
- R2: A write to control (0x0) while the block is disabled sets enable from data bit 0 and mode from data bit 1. A read of 0x0 returns enable in bit 0 and mode in bit 1.
- R3: While the block is enabled, writes to control are ignored. Writing 0 neither disables the watchdog nor changes the mode, and the running count is not affected.
- R4: The range register (0x4) stores data bits [7:0] and reads them back. Bits [3:0] are the reload code and bits [7:4] are the initial code. Code n means a period of 2^(BASE_LOG2+n) cycles.
- R5: In mode 0, when a write that enables the block is taken on clock edge k, `sys_rst` first reads high after edge k+P_init, where P_init comes from the initial code.
- R6: A write of exactly 0x76 (full data word) to 0x0C while the block is enabled restarts the count. After a restart on edge e, the next expiry comes at edge e+P_rel. A restart on the edge on which expiry would take place still prevents that expiry.
- R7: A write of any other value to 0x0C has no effect on the count.
- R8: In mode 1, the first expiry sets `irq` and reloads with P_rel. A second expiry while `irq` is still set raises `sys_rst`.
- R9: A valid restart write clears `irq` from the next cycle on.
- R10: `sys_rst` stays high for exactly PULSE_LEN (8) cycles. After that the block is halted: it gives no further pulse and ignores restarts until it is reset.
- R11: A read of the restart register (0x0C) or of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | First-stage warning in mode 1 |
| sys_rst | output | 1 | System-reset pulse, active high |

## Verification
Some properties are checked by assertions on every cycle:
- the enable and mode lock while the block is running;
- the counter stepping down by one between loads;
- the interrupt clearing after a valid restart;
- the interrupt appearing only in mode 1;
- the halted state being sticky, with no second reset pulse.

Other behaviour can only be shown by the bench's scenarios. Expiry landing on the exact edge given by the initial and reload codes is one such case. Others are a restart on the expiry edge, non-key writes leaving the deadline unchanged, and the two-stage sequence in mode 1. The bench uses a small BASE_LOG2 so that these edge counts stay short.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int unsigned CODE_W   = 4;
   localparam int unsigned NUM_CODE = 1 << CODE_W;
   localparam int unsigned OFS_CTRL  = 'h0;
   localparam int unsigned OFS_RANGE = 'h4;
   localparam int unsigned OFS_KICK  = 'hC;

   typedef struct packed {
      logic mode;
      logic en;
   } ctl_t;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter logic [7:0]  KEY    = 8'h76
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              live,
   output ctl_t              ctl,
   output logic [CODE_W-1:0] code_init,
   output logic [CODE_W-1:0] code_rel,
   output logic              start,
   output logic              kick
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);
   localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
   localparam int unsigned       RNG_W   = 2 * CODE_W;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("kwd_regs: ADDR_W must be at least 4");
   end
   if (DATA_W < RNG_W) begin : g_bad_data
      $error("kwd_regs: DATA_W must hold the range field");
   end

   logic [RNG_W-1:0] rng_q;
   logic             hit_ctrl, hit_range, hit_kick;

   assign hit_ctrl  = bus_addr == A_CTRL;
   assign hit_range = bus_addr == A_RANGE;
   assign hit_kick  = bus_addr == A_KICK;

   assign start = bus_we && hit_ctrl && !ctl.en && bus_wdata[0];
   assign kick  = bus_we && hit_kick && live && (bus_wdata == DATA_W'(KEY));

   assign code_rel  = rng_q[CODE_W-1:0];
   assign code_init = rng_q[RNG_W-1:CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl   <= '0;
         rng_q <= '0;
      end else if (bus_we) begin
         if (hit_ctrl && !ctl.en) begin
            ctl.en   <= bus_wdata[0];
            ctl.mode <= bus_wdata[1];
         end
         if (hit_range) begin
            rng_q <= bus_wdata[RNG_W-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[1:0] = {ctl.mode, ctl.en};
      end else if (hit_range) begin
         bus_rdata[RNG_W-1:0] = rng_q;
      end
   end

   // R3
   en_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.en |=> ctl.en);
   // R3
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.en |=> $stable(ctl.mode));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
   import kwd_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned BASE_LOG2 = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   output logic              zero
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("kwd_counter: BASE_LOG2 must be at least 1");
   end
   if (BASE_LOG2 + NUM_CODE - 1 > CNT_W) begin : g_bad_width
      $error("kwd_counter: CNT_W too narrow for the longest period");
   end

   logic [CNT_W-1:0] per_tab [NUM_CODE];
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] load_val;

   for (genvar g = 0; g < NUM_CODE; g++) begin : g_period
      assign per_tab[g] = (ONE << (BASE_LOG2 + g)) - ONE;
   end

   assign load_val = per_tab[code];
   assign zero     = count == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (run && !zero) begin
         count <= count - ONE;
      end
   end

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !zero) |=> count == $past(count) - ONE);
endmodule

// File: rtl/kwd_resp.sv
module kwd_resp #(
   parameter int unsigned PULSE_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mode,
   input  logic zero,
   input  logic kick,
   output logic halted,
   output logic reload,
   output logic irq,
   output logic sys_rst
);
   localparam int unsigned PCNT_W = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("kwd_resp: PULSE_LEN must be at least 1");
   end

   logic [PCNT_W-1:0] pcnt;
   logic              expire, fatal;

   assign expire  = en && !halted && zero && !kick;
   assign reload  = expire && mode && !irq;
   assign fatal   = expire && (!mode || irq);
   assign sys_rst = pcnt != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq    <= 1'b0;
         halted <= 1'b0;
         pcnt   <= '0;
      end else begin
         if (kick) begin
            irq <= 1'b0;
         end else if (reload) begin
            irq <= 1'b1;
         end
         if (fatal) begin
            halted <= 1'b1;
            pcnt   <= PCNT_W'(PULSE_LEN);
         end else if (pcnt != '0) begin
            pcnt <= pcnt - PCNT_W'(1);
         end
      end
   end

   // R9
   kick_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !irq);
   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   // R10
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !sys_rst) |=> !sys_rst);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned BASE_LOG2 = 16,
   parameter int unsigned PULSE_LEN = 8,
   parameter logic [7:0]  KEY       = 8'h76
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sys_rst
);
   ctl_t              ctl;
   logic [CODE_W-1:0] code_init, code_rel, code_sel;
   logic              start, kick, reload, halted, zero, run, load;

   assign run      = ctl.en && !halted;
   assign load     = start || kick || reload;
   assign code_sel = start ? code_init : code_rel;

   kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .live      (run),
      .ctl       (ctl),
      .code_init (code_init),
      .code_rel  (code_rel),
      .start     (start),
      .kick      (kick)
   );

   kwd_counter #(.CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .load  (load),
      .code  (code_sel),
      .zero  (zero)
   );

   kwd_resp #(.PULSE_LEN(PULSE_LEN)) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl.en),
      .mode    (ctl.mode),
      .zero    (zero),
      .kick    (kick),
      .halted  (halted),
      .reload  (reload),
      .irq     (irq),
      .sys_rst (sys_rst)
   );

   // R8
   irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctl.mode);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   localparam int BASE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sys_rst;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   keyed_watchdog #(.BASE_LOG2(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst)
   );

   function automatic int per(input int code);
      return 1 << (BASE + code);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int mark, dl, e, ci, cr, nk;
      bit bad, inval;

      do_reset;
      // R1 reset state
      check("R1 sys_rst", {31'b0, sys_rst}, 0);
      check("R1 irq", {31'b0, irq}, 0);
      rd(4'h0, d); check("R1 ctrl", d, 0);
      rd(4'h4, d); check("R1 range", d, 0);

      // R4 range read-back, R11 restart and unmapped reads
      wr(4'h4, 32'hFFFF_FFA5);
      rd(4'h4, d); check("R4 range readback", d, 32'hA5);
      rd(4'hC, d); check("R11 restart read", d, 0);
      rd(4'h8, d); check("R11 unmapped read", d, 0);

      // R5 / R10 mode 0, initial code 2, reload code 1
      do_reset;
      wr(4'h4, 32'h21);
      wr(4'h0, 32'h1);
      mark = cyc;
      rd(4'h0, d); check("R2 ctrl mode0", d, 1);
      wait_until(mark + per(2) - 1); check("R5 before expiry", {31'b0, sys_rst}, 0);
      wait_until(mark + per(2));     check("R5 expiry edge", {31'b0, sys_rst}, 1);
      wait_until(mark + per(2) + 7); check("R10 pulse last", {31'b0, sys_rst}, 1);
      wait_until(mark + per(2) + 8); check("R10 pulse end", {31'b0, sys_rst}, 0);
      wr(4'hC, 32'h76);
      bad = 1'b0;
      repeat (200) begin
         @(negedge clk);
         if (sys_rst !== 1'b0) bad = 1'b1;
      end
      check("R10 halted no pulse", {31'b0, bad}, 0);

      // R3 writes to control ignored while enabled
      do_reset;
      wr(4'h4, 32'h11);
      wr(4'h0, 32'h1);
      mark = cyc;
      wr(4'h0, 32'h2);
      wr(4'h0, 32'h0);
      rd(4'h0, d); check("R3 ctrl locked", d, 1);
      wait_until(mark + per(1) - 1); check("R3 still counting", {31'b0, sys_rst}, 0);
      wait_until(mark + per(1));     check("R3 expiry unchanged", {31'b0, sys_rst}, 1);

      // R6 restart on the expiry edge itself
      do_reset;
      wr(4'h4, 32'h00);
      wr(4'h0, 32'h1);
      dl = cyc + per(0);
      wait_until(dl - 1);
      wr(4'hC, 32'h76);
      check("R6 kick on expiry edge", {31'b0, sys_rst}, 0);
      dl = cyc + per(0);
      wait_until(dl - 1); check("R6 after late kick", {31'b0, sys_rst}, 0);
      wait_until(dl);     check("R6 reload expiry", {31'b0, sys_rst}, 1);

      // R6 / R7 random restart schedules, mode 0
      for (int it = 0; it < 8; it++) begin
         do_reset;
         ci = $urandom % 3;
         cr = $urandom % 3;
         wr(4'h4, 32'((ci << 4) | cr));
         wr(4'h0, 32'h1);
         dl = cyc + per(ci);
         nk = 1 + ($urandom % 4);
         for (int k = 0; k < nk; k++) begin
            e = cyc + 1 + ($urandom % (dl - 1 - cyc));
            if ((e - 1 > cyc) && ($urandom % 2 == 1)) begin
               d = $urandom;
               if (d == 32'h76) d = 32'h77;
               wr(4'hC, d);
            end
            wait_until(e - 1);
            check("R6 alive before kick", {31'b0, sys_rst}, 0);
            wr(4'hC, 32'h76);
            dl = cyc + per(cr);
         end
         inval = ($urandom % 2 == 1);
         if (inval) wr(4'hC, 32'h0000_0176);
         wait_until(dl - 1);
         check(inval ? "R7 invalid key ignored" : "R6 before expiry", {31'b0, sys_rst}, 0);
         wait_until(dl);
         check(inval ? "R7 deadline kept" : "R6 expiry after kick", {31'b0, sys_rst}, 1);
      end

      // R8 / R9 two-stage mode
      do_reset;
      wr(4'h4, 32'h10);
      wr(4'h0, 32'h3);
      mark = cyc;
      rd(4'h0, d); check("R2 ctrl mode1", d, 3);
      wait_until(mark + per(1) - 1); check("R8 irq low", {31'b0, irq}, 0);
      wait_until(mark + per(1));     check("R8 irq first expiry", {31'b0, irq}, 1);
      check("R8 no reset first", {31'b0, sys_rst}, 0);
      wr(4'hC, 32'h76);
      check("R9 irq cleared", {31'b0, irq}, 0);
      dl = cyc + per(0);
      wait_until(dl); check("R8 irq again", {31'b0, irq}, 1);
      dl = dl + per(0);
      wait_until(dl - 1); check("R8 before second", {31'b0, sys_rst}, 0);
      wait_until(dl);     check("R8 second expiry reset", {31'b0, sys_rst}, 1);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule